// File: doc/BRIEF.md
# Triple-Output Recovery Output Buffer

This block sits between the combinational logic of a double-time-redundant circuit and one primary output vector. In normal operation every result reaches the combinational output twice in a row: two identical samples form a pair. The block hands each value on three cycles after it first appears. The outputs are valid in the cycles where the checkpoint strobe `save` is high. A reader samples the three copies only in those cycles and votes on them.

An external controller reacts to a detected fault by running a rollback and re-execution episode. During that episode the combinational output stream is shifted and compressed. The block hides this with two independent storage chains and per-output tap multiplexers. The reader therefore sees the same value sequence as an unfaulted run, with one new value every two cycles. The block also compares two successive samples of the combinational output and drives a local mismatch flag. The controller ORs this flag into its global fault signal.

The only state outside the two storage chains is a small tracker with two states. `TRACK_RUN` is the normal state. `TRACK_ROLL` means `roll_back` was high in the previous cycle. Transition `RUN->ROLL` is taken on any cycle with `roll_back` high. Transition `ROLL->RUN` is taken on any cycle with `roll_back` low. The tracker steers lane C in the first valid cycle after an episode.

Top module: `trio_out_buffer`

## Requirements
- R1: While `rst_n` is low, every storage cell holds the parameter value `INIT`. In the first cycle after reset is released, `out_a`, `out_b` and `out_c` all equal `INIT` and `mismatch` is 0.
- R2: In normal operation (`subst_en` and `roll_back` low, and `roll_back` low in the previous cycle), each valid cycle t (`save` high) shows on all three outputs the value that `comb_out` carried two and three cycles before. This gives a three-cycle latency from the first sample of a pair.
- R3: `mismatch` in cycle t is 1 exactly when the `comb_out` value of cycle t-1 differs from that of cycle t-2.
- R4: In the first replay slot (`subst_en`, `roll_back` and `save` high, with `roll_back` low in the previous cycle), all three outputs show the `comb_out` value of three cycles earlier.
- R5: In the second replay slot (`subst_en` and `roll_back` high, `save` low, and `save` low in the previous cycle), all three outputs show the `comb_out` value of the previous cycle.
- R6: In the first valid cycle after an episode (`roll_back` low, `save` high, `roll_back` high in the previous cycle), all three outputs show the `comb_out` value of two cycles earlier.
- R7: If exactly one of `save`, `roll_back` or `subst_en` is inverted for one cycle during normal operation, at least two of the three outputs still carry the reference value at every valid cycle.
- R8: A single corrupted `comb_out` sample in a valid cycle raises `mismatch` in the next cycle. With the standard episode then driven (`roll_back` for four cycles, `subst_en` for the first three, `save` high only in the first), all three outputs match the unfaulted reference at every valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| comb_out | input | W | Upsampled output of the combinational logic |
| save | input | 1 | Checkpoint strobe; high in valid output cycles |
| roll_back | input | 1 | High for the four cycles of a recovery episode |
| subst_en | input | 1 | High for the first three cycles of an episode |
| out_a | output | W | Redundant output copy A (o chain, lane A taps) |
| out_b | output | W | Redundant output copy B (p chain) |
| out_c | output | W | Redundant output copy C (o chain, lane C taps) |
| mismatch | output | 1 | Local fault flag from the pair comparator |

## Verification
A clean run of random paired values sets the baseline latency and confirms that the three copies agree, with the comparator staying silent. Corrupted samples with random bit masks are injected at valid cycles. Each one is followed by a model-driven episode, which separates the three replay slots from one another and from steady state. Single-cycle inversions of each control line, placed at both cycle parities, show that a wrong select or a missed capture touches only one lane while the vote still recovers the reference.

// File: rtl/trio_out_pkg.sv
package trio_out_pkg;

    // Which stage of a storage chain a lane presents
    typedef enum logic [1:0] {
        PICK_MID,
        PICK_OLD,
        PICK_NEW
    } pick_e;

    // Recovery tracker states
    typedef enum logic {
        TRACK_RUN,
        TRACK_ROLL
    } track_e;

endpackage

// File: rtl/trio_shift.sv
module trio_shift #(
    parameter int              W     = 8,
    parameter int              DEPTH = 3,
    parameter logic [W-1:0]    INIT  = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [W-1:0]               din,
    output logic [DEPTH-1:0][W-1:0]    taps
);

    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stg[k] <= INIT;
        end else if (en) begin
            stg[0] <= din;
            for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        assign taps[g] = stg[g];
    end

endmodule

// File: rtl/trio_compare.sv
module trio_compare #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         neq
);

    assign neq = |(lhs ^ rhs);

endmodule

// File: rtl/trio_pick.sv
module trio_pick #(
    parameter int W = 8
) (
    input  trio_out_pkg::pick_e sel,
    input  logic [W-1:0]        newest,
    input  logic [W-1:0]        middle,
    input  logic [W-1:0]        oldest,
    output logic [W-1:0]        y
);
    import trio_out_pkg::*;

    always_comb begin
        y = middle;
        unique case (sel)
            PICK_NEW: y = newest;
            PICK_MID: y = middle;
            PICK_OLD: y = oldest;
            default:  y = middle;
        endcase
    end

endmodule

// File: rtl/trio_out_buffer.sv
module trio_out_buffer #(
    parameter int           W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] comb_out,
    input  logic         save,
    input  logic         roll_back,
    input  logic         subst_en,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b,
    output logic [W-1:0] out_c,
    output logic         mismatch
);
    import trio_out_pkg::*;

    localparam int O_DEPTH = 3;
    localparam int P_DEPTH = 2;

    logic [O_DEPTH-1:0][W-1:0] o_taps;
    logic [P_DEPTH-1:0][W-1:0] p_taps;
    track_e                    st_q, st_d;
    pick_e                     sel_a, sel_b, sel_c;

    // Free-running chain: o, o', o''
    trio_shift #(.W(W), .DEPTH(O_DEPTH), .INIT(INIT)) u_ochain (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (1'b1),
        .din  (comb_out),
        .taps (o_taps)
    );

    // Isolated chain p, p' loaded only in detection-side cycles
    trio_shift #(.W(W), .DEPTH(P_DEPTH), .INIT(INIT)) u_pchain (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (~save),
        .din  (comb_out),
        .taps (p_taps)
    );

    trio_compare #(.W(W)) u_cmp (
        .lhs(o_taps[0]),
        .rhs(o_taps[1]),
        .neq(mismatch)
    );

    // Tracker next state
    always_comb begin
        st_d = roll_back ? TRACK_ROLL : TRACK_RUN;
    end

    // Tracker register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRACK_RUN;
        else        st_q <= st_d;
    end

    // Lane selects: each lane decodes its own subset of the controls
    always_comb begin
        sel_a = PICK_MID;
        sel_b = PICK_MID;
        sel_c = PICK_OLD;
        if (subst_en) sel_a = save ? PICK_OLD : PICK_NEW;
        if (subst_en && !save) sel_b = PICK_NEW;
        unique case (st_q)
            TRACK_RUN: begin
                if (roll_back && !save) sel_c = PICK_NEW;
            end
            TRACK_ROLL: begin
                if (roll_back && !save)      sel_c = PICK_NEW;
                else if (!roll_back && save) sel_c = PICK_MID;
            end
            default: sel_c = PICK_OLD;
        endcase
    end

    trio_pick #(.W(W)) u_pick_a (
        .sel(sel_a), .newest(o_taps[0]), .middle(o_taps[1]), .oldest(o_taps[2]), .y(out_a)
    );

    trio_pick #(.W(W)) u_pick_b (
        .sel(sel_b), .newest(p_taps[0]), .middle(p_taps[1]), .oldest(p_taps[1]), .y(out_b)
    );

    trio_pick #(.W(W)) u_pick_c (
        .sel(sel_c), .newest(o_taps[0]), .middle(o_taps[1]), .oldest(o_taps[2]), .y(out_c)
    );

endmodule

// File: rtl/trio_out_chk.sv
module trio_out_chk #(
    parameter int           W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] comb_out,
    input logic         save,
    input logic         roll_back,
    input logic         subst_en,
    input logic [W-1:0] out_a,
    input logic [W-1:0] out_b,
    input logic [W-1:0] out_c,
    input logic         mismatch
);

    logic [2:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            since <= '0;
        else if (since != 3'd7) since <= since + 3'd1;
    end

    // R1
    rst_init_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (out_a == INIT && out_b == INIT && out_c == INIT && !mismatch));

    // R2
    steady_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd3 && save && !subst_en && !roll_back && !$past(roll_back))
        |-> (out_a == $past(comb_out, 2) && out_c == $past(comb_out, 3)));

    // R3
    pair_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd2) |-> (mismatch == ($past(comb_out, 1) != $past(comb_out, 2))));

    // R4
    early_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd3 && subst_en && save && roll_back && !$past(roll_back))
        |-> (out_a == $past(comb_out, 3) && out_c == $past(comb_out, 3)));

    // R5
    late_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd1 && subst_en && roll_back && !save && !$past(save))
        |-> (out_a == $past(comb_out, 1) && out_b == $past(comb_out, 1)
             && out_c == $past(comb_out, 1)));

    // R6
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd3 && save && !roll_back && !subst_en && $past(roll_back))
        |-> (out_a == $past(comb_out, 2) && out_c == $past(comb_out, 2)));

endmodule

bind trio_out_buffer trio_out_chk #(.W(W), .INIT(INIT)) u_trio_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .comb_out (comb_out),
    .save     (save),
    .roll_back(roll_back),
    .subst_en (subst_en),
    .out_a    (out_a),
    .out_b    (out_b),
    .out_c    (out_c),
    .mismatch (mismatch)
);

// File: tb/tb_trio_out_buffer.sv
module tb_trio_out_buffer;

    localparam int           W    = 8;
    localparam logic [W-1:0] INIT = 8'h00;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] comb_out;
    logic         save, roll_back, subst_en;
    logic [W-1:0] out_a, out_b, out_c;
    logic         mismatch;

    always #5 clk = ~clk;

    trio_out_buffer #(.W(W), .INIT(INIT)) dut (
        .clk(clk), .rst_n(rst_n), .comb_out(comb_out), .save(save),
        .roll_back(roll_back), .subst_en(subst_en),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .mismatch(mismatch)
    );

    int           checks = 0;
    int           errs   = 0;
    bit           done   = 0;
    logic [W-1:0] xv [0:255];
    int           c      = 0;
    int           rec    = 0;
    int           det    = -100;
    int           inj    = -100;
    logic [W-1:0] h1 = INIT, h2 = INIT;

    // Unfaulted output expected at valid cycle t
    function automatic logic [W-1:0] ref_at(int t);
        return (t < 3) ? INIT : xv[(t - 2) >> 1];
    endfunction

    // Combinational output stream, including the shifted replay episode
    function automatic logic [W-1:0] co_model(int t, int r, int d);
        if (r == 1) return xv[(d - 1) >> 1];
        if (r == 2) return xv[(d + 1) >> 1];
        if (r == 3) return xv[(d + 3) >> 1];
        return xv[t >> 1];
    endfunction

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, c, act, exp);
        end
    endtask

    // glitch: 0 none, 1 save, 2 roll_back, 3 subst_en
    task automatic one_cycle(input logic [W-1:0] flip, input int glitch);
        logic         s, rb, su;
        logic [W-1:0] cov, exp, maj;
        int           ndiff;
        string        tag;
        @(negedge clk);
        if (rec > 0) begin
            rb = 1'b1; su = (rec <= 3); s = (rec == 1);
        end else begin
            rb = 1'b0; su = 1'b0; s = c[0];
        end
        cov = co_model(c, rec, det) ^ flip;
        if (flip != '0) inj = c;
        if (glitch == 1) s  = ~s;
        if (glitch == 2) rb = ~rb;
        if (glitch == 3) su = ~su;
        comb_out = cov; save = s; roll_back = rb; subst_en = su;
        #1;
        // R3: registered pair comparison
        if (c >= 2) chk(W'(mismatch), W'(h1 != h2), "R3 mismatch flag");
        // R8: corrupted valid-cycle sample flagged next cycle
        if (c == inj + 1) chk(W'(mismatch), W'(1), "R8 detection");
        if (c[0]) begin
            exp = ref_at(c);
            if (c >= 260) begin
                // R7: single control inversion, vote still correct
                maj   = (out_a == out_b) ? out_a : ((out_a == out_c) ? out_a : out_b);
                ndiff = int'(out_a != exp) + int'(out_b != exp) + int'(out_c != exp);
                chk(maj, exp, "R7 voted output");
                chk(W'(ndiff <= 1), W'(1), "R7 at most one lane off");
            end else begin
                if (c == det + 1)      tag = "R4 early replay";
                else if (c == det + 3) tag = "R5 late replay";
                else if (c == det + 5) tag = "R6 resume";
                else if (c >= 80)      tag = "R8 after fault";
                else                   tag = "R2 steady";
                chk(out_a, exp, {tag, " out_a"});
                chk(out_b, exp, {tag, " out_b"});
                chk(out_c, exp, {tag, " out_c"});
            end
        end
        h2 = h1;
        h1 = cov;
        if (rec > 0) rec = (rec == 4) ? 0 : rec + 1;
        else if (!c[0] && c >= 2 && mismatch) begin
            rec = 1;
            det = c;
        end
        c++;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 256; k++) xv[k] = W'($urandom);
        xv[5] = xv[4];
        rst_n = 1'b0; save = 1'b0; roll_back = 1'b0; subst_en = 1'b0;
        comb_out = W'($urandom);
        repeat (3) @(negedge clk);
        // R1: reset state with arbitrary inputs
        for (int k = 0; k < 3; k++) begin
            comb_out = W'($urandom); save = k[0]; subst_en = k[1]; roll_back = k[0];
            #1;
            chk(out_a, INIT, "R1 reset out_a");
            chk(out_b, INIT, "R1 reset out_b");
            chk(out_c, INIT, "R1 reset out_c");
            chk(W'(mismatch), W'(0), "R1 reset mismatch");
            @(negedge clk);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] fm;
            int           gl;
            fm = '0;
            gl = 0;
            if (c >= 91 && c < 250 && ((c - 91) % 20) == 0) fm = W'($urandom_range(1, 255));
            if (c >= 265 && ((c - 265) % 9) == 0) gl = ((c - 265) / 9) % 3 + 1;
            one_cycle(fm, gl);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end

endmodule